// File: doc/BRIEF.md
# Add/Subtract Unit with Signed Overflow Flag

This block is a purely combinational arithmetic unit that either adds or subtracts two 8-bit words. A single mode input chooses the operation. The result is always the low 8 bits of the exact sum or difference. It therefore wraps modulo 256, and the same bit pattern is correct whether the operands are read as unsigned or as two's-complement signed values.

A separate flag tells the consumer when the signed result did not fit in 8 bits. The unit has one adder. Subtraction feeds the inverted second operand and a carry of one into that same adder. A small control module turns the mode bit into the strobes for inversion and carry. The datapath module holds the inversion stage, the ripple carry chain and the overflow logic.

Top module: `addsub_unit`

## Requirements
- R1: With `addMode` = 1, `sum` equals (`opA` + `opB`) modulo 256.
- R2: With `addMode` = 0, `sum` equals (`opA` - `opB`) modulo 256.
- R3: With `addMode` = 1, `ovf` is 1 exactly when `opA` and `opB` have equal bit 7 and `sum` bit 7 differs from it.
- R4: With `addMode` = 0, `ovf` is 1 exactly when `opA` and `opB` differ in bit 7 and `sum` bit 7 differs from `opA` bit 7.
- R5: The result bits do not depend on signed or unsigned interpretation: 0x81 + 0x01 gives 0x82, with `ovf` = 0.
- R6: Overflow leaves the wrapped result unchanged. 0x7F + 0x01 gives 0x80 with `ovf` = 1, and 0x80 - 0x01 gives 0x7F with `ovf` = 1.
- R7: With both operands zero, `sum` is 0x00 and `ovf` is 0 in either mode.
- R8: `ovf` is 1 exactly when the two's-complement integer result lies outside -128..127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First operand (minuend in subtract mode) |
| opB | input | 8 | Second operand (subtrahend in subtract mode) |
| addMode | input | 1 | 1 selects opA + opB, 0 selects opA - opB |
| sum | output | 8 | Wrapped result, modulo 256 |
| ovf | output | 1 | Signed overflow flag |

## Verification
Both modes are swept over every pair of operands. Each output is compared with plain integer arithmetic on the sign-extended values. This sweep separates a correct carry chain from one with a wrong inversion, a missing carry-in or a swapped mode decode.

A short table of directed vectors comes first. It covers zero operands, the most negative value, the two classic wrap cases and the mixed-sign edges of subtraction. These vectors show whether the overflow flag uses the add rule or the subtract rule, and whether it ever changes the result bits.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  // Strobes the control module sends to the datapath.
  typedef struct packed {
    logic invertB;  // feed the bitwise complement of opB into the adder
    logic carryIn;  // carry into bit 0 of the adder
  } addsub_strobe_t;
endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic           addMode,
  output addsub_strobe_t strobes
);
  // Subtraction is opA + ~opB + 1, so both strobes follow the inverted mode bit.
  always_comb begin
    strobes.invertB = ~addMode;
    strobes.carryIn = ~addMode;
  end
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  addsub_strobe_t   strobes,
  output logic [WIDTH-1:0] sum,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   carry;

  // Conditional inversion of the second operand, one XOR per bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_inv
    assign bEff[i] = opB[i] ^ strobes.invertB;
  end

  // Ripple carry chain shared by both operations.
  always_comb begin
    carry[0] = strobes.carryIn;
    for (int i = 0; i < WIDTH; i++) begin
      sum[i]     = opA[i] ^ bEff[i] ^ carry[i];
      carry[i+1] = (opA[i] & bEff[i]) | (carry[i] & (opA[i] ^ bEff[i]));
    end
  end

  // Signed overflow: the carry into the sign bit disagrees with the carry out of it.
  assign ovf = carry[WIDTH] ^ carry[MSB];

  // Sign-rule checks against the carry-based flag.
  always_comb begin
    if (!strobes.invertB) begin
      a_r3_add_overflow: assert (ovf == ((opA[MSB] == opB[MSB]) && (sum[MSB] != opA[MSB])))
        else $error("R3 add overflow rule broken");
    end else begin
      a_r4_sub_overflow: assert (ovf == ((opA[MSB] != opB[MSB]) && (sum[MSB] != opA[MSB])))
        else $error("R4 subtract overflow rule broken");
    end
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             addMode,
  output logic [WIDTH-1:0] sum,
  output logic             ovf
);
  addsub_strobe_t strobes;

  addsub_ctrl u_ctrl (
    .addMode (addMode),
    .strobes (strobes)
  );

  addsub_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .sum     (sum),
    .ovf     (ovf)
  );

  // Result checks across the control/datapath boundary.
  always_comb begin
    if (addMode) begin
      a_r1_add_result: assert (sum == WIDTH'(opA + opB))
        else $error("R1 add result wrong");
    end else begin
      a_r2_sub_result: assert (sum == WIDTH'(opA - opB))
        else $error("R2 subtract result wrong");
    end
    if (opA == '0 && opB == '0) begin
      a_r7_zero_operands: assert (sum == '0 && !ovf)
        else $error("R7 zero operands gave nonzero output");
    end
  end
endmodule

// File: tb/addsub_unit_bench.sv
module addsub_unit_bench;
  logic       clk = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic       addMode = 1'b1;
  logic [7:0] sum;
  logic       ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  addsub_unit u_addsub_unit (
    .opA     (opA),
    .opB     (opB),
    .addMode (addMode),
    .sum     (sum),
    .ovf     (ovf)
  );

  // Vector fields: {opA, opB, addMode, expected sum, expected ovf}
  localparam int NVEC = 12;
  localparam logic [25:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 1'b1, 8'h00, 1'b0},  // R7
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0},  // R7
    {8'h81, 8'h01, 1'b1, 8'h82, 1'b0},  // R5
    {8'h7F, 8'h01, 1'b1, 8'h80, 1'b1},  // R6, R3
    {8'h80, 8'h01, 1'b0, 8'h7F, 1'b1},  // R6, R4
    {8'h80, 8'h80, 1'b1, 8'h00, 1'b1},  // R3
    {8'hFF, 8'hFF, 1'b1, 8'hFE, 1'b0},  // R1
    {8'h05, 8'h03, 1'b0, 8'h02, 1'b0},  // R2
    {8'h03, 8'h05, 1'b0, 8'hFE, 1'b0},  // R2
    {8'h00, 8'h80, 1'b0, 8'h80, 1'b1},  // R4
    {8'h7F, 8'hFF, 1'b0, 8'h80, 1'b1},  // R4
    {8'h80, 8'h7F, 1'b1, 8'hFF, 1'b0}   // R3
  };

  task automatic checkOut(input string req, input logic [7:0] expSum, input logic expOvf);
    checks++;
    if (sum !== expSum || ovf !== expOvf) begin
      errors++;
      $display("FAIL %s a=%h b=%h mode=%b: sum=%h ovf=%b expected sum=%h ovf=%b",
               req, opA, opB, addMode, sum, ovf, expSum, expOvf);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // Idle state: zero operands in add mode (R7)
    checkOut("R7", 8'h00, 1'b0);

    // Directed table
    for (int k = 0; k < NVEC; k++) begin
      opA     = VEC[k][25:18];
      opB     = VEC[k][17:10];
      addMode = VEC[k][9];
      #5;
      checkOut("R1-table", VEC[k][8:1], VEC[k][0]);
    end

    // Corner cases, called out by name
    opA = 8'h81; opB = 8'h01; addMode = 1'b1; #5; checkOut("R5", 8'h82, 1'b0);
    opA = 8'h7F; opB = 8'h01; addMode = 1'b1; #5; checkOut("R6", 8'h80, 1'b1);
    opA = 8'h80; opB = 8'h01; addMode = 1'b0; #5; checkOut("R6", 8'h7F, 1'b1);
    opA = 8'h00; opB = 8'h00; addMode = 1'b0; #5; checkOut("R7", 8'h00, 1'b0);

    // Exhaustive sweep against integer arithmetic (R1, R2, R3, R4, R8)
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          int sa, sb, sr;
          logic [7:0] expSum;
          logic expOvf;
          opA = 8'(a); opB = 8'(b); addMode = m[0];
          sa = (a > 127) ? a - 256 : a;
          sb = (b > 127) ? b - 256 : b;
          sr = m[0] ? sa + sb : sa - sb;
          expSum = 8'(sr);
          expOvf = (sr > 127) || (sr < -128);
          #5;
          checkOut(m[0] ? "R1/R3/R8" : "R2/R4/R8", expSum, expOvf);
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule